// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is the combinational execute stage of a 32-bit load-store core. An operation code selects one of 24 functions. The functions are two-operand arithmetic in trapping and non-trapping forms, bitwise logic, signed and unsigned set-on-less-than, constant and variable shifts, and a load of the upper half-word. The block widens the 16-bit immediate itself. It zero-extends the immediate for the logic forms and sign-extends it for the arithmetic and compare forms.

The trapping add and subtract forms raise an overflow flag on two's-complement overflow. In the same cycle they raise a write-block output, so the core can suppress the register write and hand control to its exception logic. The wrapped result is still driven. Every function drives all 32 result bits.

Top module: `int_alu`

## Requirements
- R1: The operation codes on `op_sel` are: 0 ADD, 1 ADDU, 2 SUB, 3 SUBU, 4 ADDI, 5 ADDIU, 6 AND, 7 OR, 8 XOR, 9 NOR, 10 ANDI, 11 ORI, 12 XORI, 13 SLT, 14 SLTU, 15 SLTI, 16 SLTIU, 17 SLL, 18 SRL, 19 SRA, 20 SLLV, 21 SRLV, 22 SRAV, 23 LUI. Any code from 24 to 31 gives result 0 with both flags low.
- R2: ADD, ADDU, SUB and SUBU produce src_a+src_b and src_a-src_b modulo 2^32.
- R3: ADD, SUB and ADDI raise `ovf_trap` and `wr_block` together whenever the signed result does not fit in 32 bits, and keep both low otherwise.
- R4: ADDU, SUBU, ADDIU, the logic operations, the compares, the shifts and LUI never raise `ovf_trap` or `wr_block`.
- R5: ANDI, ORI and XORI use the immediate zero-extended to 32 bits. ADDI, ADDIU, SLTI and SLTIU use it sign-extended from bit 15.
- R6: AND, OR, XOR and NOR are bitwise on src_a and src_b. NOR gives ~(src_a|src_b).
- R7: SLT and SLTI give 1 when src_a is below the second operand as two's-complement numbers, and 0 otherwise. SLTU and SLTIU do the same comparison unsigned. SLTIU compares against the sign-extended immediate.
- R8: SLL, SRL and SRA shift src_b by `shamt`. SLL and SRL fill the vacated bits with zeros, and SRA fills them with bit 31 of src_b.
- R9: SLLV, SRLV and SRAV shift src_b by src_a[4:0] and ignore src_a[31:5].
- R10: LUI gives {imm, 16'h0000}.
- R11: When the overflow flag is raised, `result` still carries the wrapped 32-bit sum or difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code |
| src_a | input | 32 | First register operand, also the variable shift amount |
| src_b | input | 32 | Second register operand, also the value shifted |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow exception request |
| wr_block | output | 1 | Suppress the destination register write |

## Verification
Immediate assertions are checked every time the inputs change. They cover these properties:
- the non-trapping operations never raise a flag;
- the trapping add only flags when its operands have the same sign;
- the compare results are 0 or 1;
- LUI clears the low half-word;
- NOR shares no bit with the OR of its operands.

The exact results, the choice between zero and sign extension, the fill bits of the shifts and the boundary overflow values need the bench's reference model. The bench runs directed corner cases and random operands for every code.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [4:0]                 op_sel,
  input  logic [DATA_W-1:0]          src_a,
  input  logic [DATA_W-1:0]          src_b,
  input  logic [IMM_W-1:0]           imm,
  input  logic [$clog2(DATA_W)-1:0]  shamt,
  output logic [DATA_W-1:0]          result,
  output logic                       ovf_trap,
  output logic                       wr_block
);
  localparam int SH_W = $clog2(DATA_W);
  localparam int EXT_W = DATA_W - IMM_W;

  localparam logic [4:0] OP_ADD = 5'd0, OP_ADDU = 5'd1, OP_SUB = 5'd2, OP_SUBU = 5'd3;
  localparam logic [4:0] OP_ADDI = 5'd4, OP_ADDIU = 5'd5;
  localparam logic [4:0] OP_AND = 5'd6, OP_OR = 5'd7, OP_XOR = 5'd8, OP_NOR = 5'd9;
  localparam logic [4:0] OP_ANDI = 5'd10, OP_ORI = 5'd11, OP_XORI = 5'd12;
  localparam logic [4:0] OP_SLT = 5'd13, OP_SLTU = 5'd14, OP_SLTI = 5'd15, OP_SLTIU = 5'd16;
  localparam logic [4:0] OP_SLL = 5'd17, OP_SRL = 5'd18, OP_SRA = 5'd19;
  localparam logic [4:0] OP_SLLV = 5'd20, OP_SRLV = 5'd21, OP_SRAV = 5'd22, OP_LUI = 5'd23;

  logic [DATA_W-1:0] imm_sx, imm_zx, opnd_b, sum, diff, shifted, res_c;
  logic [SH_W-1:0]   sh_amt;
  logic              use_sx, use_zx, var_sh, add_ovf, sub_ovf, trap_c;
  logic              lt_s, lt_u;

  assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign imm_zx = {{EXT_W{1'b0}}, imm};

  assign use_sx = (op_sel == OP_ADDI) || (op_sel == OP_ADDIU) ||
                  (op_sel == OP_SLTI) || (op_sel == OP_SLTIU);
  assign use_zx = (op_sel == OP_ANDI) || (op_sel == OP_ORI) || (op_sel == OP_XORI);
  assign opnd_b = use_sx ? imm_sx : (use_zx ? imm_zx : src_b);

  assign sum  = src_a + opnd_b;
  assign diff = src_a - opnd_b;
  assign add_ovf = (src_a[DATA_W-1] == opnd_b[DATA_W-1]) && (sum[DATA_W-1] != src_a[DATA_W-1]);
  assign sub_ovf = (src_a[DATA_W-1] != opnd_b[DATA_W-1]) && (diff[DATA_W-1] != src_a[DATA_W-1]);

  assign lt_s = $signed(src_a) < $signed(opnd_b);
  assign lt_u = src_a < opnd_b;

  assign var_sh = (op_sel == OP_SLLV) || (op_sel == OP_SRLV) || (op_sel == OP_SRAV);
  assign sh_amt = var_sh ? src_a[SH_W-1:0] : shamt;

  always_comb begin
    case (op_sel)
      OP_SLL, OP_SLLV: shifted = src_b << sh_amt;
      OP_SRL, OP_SRLV: shifted = src_b >> sh_amt;
      default:         shifted = DATA_W'($signed(src_b) >>> sh_amt);
    endcase
  end

  always_comb begin
    trap_c = 1'b0;
    case (op_sel)
      OP_ADD, OP_ADDI:               begin res_c = sum; trap_c = add_ovf; end
      OP_SUB:                        begin res_c = diff; trap_c = sub_ovf; end
      OP_ADDU, OP_ADDIU:             res_c = sum;
      OP_SUBU:                       res_c = diff;
      OP_AND, OP_ANDI:               res_c = src_a & opnd_b;
      OP_OR, OP_ORI:                 res_c = src_a | opnd_b;
      OP_XOR, OP_XORI:               res_c = src_a ^ opnd_b;
      OP_NOR:                        res_c = ~(src_a | opnd_b);
      OP_SLT, OP_SLTI:               res_c = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU, OP_SLTIU:             res_c = {{(DATA_W-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLV, OP_SRLV, OP_SRAV:     res_c = shifted;
      OP_LUI:                        res_c = {imm, {EXT_W{1'b0}}};
      default:                       res_c = '0;
    endcase
  end

  assign result   = res_c;
  assign ovf_trap = trap_c;
  assign wr_block = trap_c;

  always_comb begin
    if (!(op_sel == OP_ADD || op_sel == OP_SUB || op_sel == OP_ADDI))
      p_no_overflow_r4: assert (!ovf_trap && !wr_block);
    if (op_sel == OP_ADD && ovf_trap)
      p_add_signs_r3: assert (src_a[DATA_W-1] == src_b[DATA_W-1] && result[DATA_W-1] != src_a[DATA_W-1]);
    if (op_sel == OP_SLT || op_sel == OP_SLTU || op_sel == OP_SLTI || op_sel == OP_SLTIU)
      p_cmp_bool_r7: assert (result[DATA_W-1:1] == '0);
    if (op_sel == OP_LUI)
      p_lui_low_r10: assert (result[EXT_W-1:0] == '0 && result[DATA_W-1:EXT_W] == imm);
    if (op_sel == OP_NOR)
      p_nor_disjoint_r6: assert ((result & (src_a | src_b)) == '0);
  end
endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_sel;
  logic [31:0] src_a, src_b, result;
  logic [15:0] imm;
  logic [4:0]  shamt;
  logic        ovf_trap, wr_block;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int_alu u_int_alu (
    .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .imm(imm), .shamt(shamt),
    .result(result), .ovf_trap(ovf_trap), .wr_block(wr_block)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string req_of(input logic [4:0] op);
    case (op)
      5'd0, 5'd2, 5'd4: return "R3";
      5'd1, 5'd3:       return "R2";
      5'd5, 5'd10, 5'd11, 5'd12: return "R5";
      5'd6, 5'd7, 5'd8, 5'd9:    return "R6";
      5'd13, 5'd14, 5'd15, 5'd16: return "R7";
      5'd17, 5'd18, 5'd19: return "R8";
      5'd20, 5'd21, 5'd22: return "R9";
      5'd23: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh,
                       output logic [31:0] r, output logic ov);
    longint sa, sb, si, t;
    logic [31:0] isx, izx;
    isx = {{16{im[15]}}, im};
    izx = {16'h0, im};
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    si = longint'($signed(isx));
    ov = 1'b0;
    r = 32'h0;
    case (op)
      5'd0: begin t = sa + sb; r = t[31:0]; ov = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      5'd2: begin t = sa - sb; r = t[31:0]; ov = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      5'd4: begin t = sa + si; r = t[31:0]; ov = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      5'd1: r = a + b;
      5'd3: r = a - b;
      5'd5: r = a + isx;
      5'd6: r = a & b;
      5'd7: r = a | b;
      5'd8: r = a ^ b;
      5'd9: r = ~(a | b);
      5'd10: r = a & izx;
      5'd11: r = a | izx;
      5'd12: r = a ^ izx;
      5'd13: r = (sa < sb) ? 32'd1 : 32'd0;
      5'd14: r = (longint'(a) < longint'(b)) ? 32'd1 : 32'd0;
      5'd15: r = (sa < si) ? 32'd1 : 32'd0;
      5'd16: r = (longint'(a) < longint'(isx)) ? 32'd1 : 32'd0;
      5'd17: r = b << sh;
      5'd18: r = b >> sh;
      5'd19: begin t = sb >>> sh; r = t[31:0]; end
      5'd20: r = b << a[4:0];
      5'd21: r = b >> a[4:0];
      5'd22: begin t = sb >>> a[4:0]; r = t[31:0]; end
      5'd23: r = {im, 16'h0};
      default: r = 32'h0;
    endcase
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%0d a=%h b=%h imm=%h sh=%0d actual=%h expected=%h",
               req, what, op_sel, src_a, src_b, imm, shamt, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh);
    logic [31:0] er;
    logic eo;
    string rq;
    @(posedge clk);
    #1;
    op_sel = op; src_a = a; src_b = b; imm = im; shamt = sh;
    model(op, a, b, im, sh, er, eo);
    rq = req_of(op);
    @(negedge clk);
    check(eo ? "R11" : rq, "result", result, er);
    check((op == 5'd0 || op == 5'd2 || op == 5'd4) ? "R3" : "R4", "ovf_trap", {31'h0, ovf_trap}, {31'h0, eo});
    check((op == 5'd0 || op == 5'd2 || op == 5'd4) ? "R3" : "R4", "wr_block", {31'h0, wr_block}, {31'h0, eo});
  endtask

  initial begin
    op_sel = 5'd0; src_a = '0; src_b = '0; imm = '0; shamt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2", "reset-state result", result, 32'h0);
    check("R3", "reset-state ovf", {31'h0, ovf_trap}, 32'h0);
    rst = 1'b0;

    apply(5'd0, 32'h7fffffff, 32'h00000001, 16'h0, 5'd0);   // R3 positive overflow, R11 wrap
    apply(5'd0, 32'h80000000, 32'hffffffff, 16'h0, 5'd0);   // R3 negative overflow
    apply(5'd0, 32'h7ffffffe, 32'h00000001, 16'h0, 5'd0);   // R3 edge, no overflow
    apply(5'd1, 32'h7fffffff, 32'h00000001, 16'h0, 5'd0);   // R4 addu no trap
    apply(5'd2, 32'h80000000, 32'h00000001, 16'h0, 5'd0);   // R3 sub overflow
    apply(5'd2, 32'h00000000, 32'h80000000, 16'h0, 5'd0);   // R3 sub overflow
    apply(5'd3, 32'h80000000, 32'h00000001, 16'h0, 5'd0);   // R2 subu
    apply(5'd4, 32'h7fffffff, 32'h0, 16'h0001, 5'd0);       // R3 addi overflow
    apply(5'd4, 32'h00000010, 32'h0, 16'h8000, 5'd0);       // R5 sign extend
    apply(5'd5, 32'h80000000, 32'h0, 16'hffff, 5'd0);       // R5 addiu, no trap
    apply(5'd10, 32'hffffffff, 32'h0, 16'h8000, 5'd0);      // R5 zero extend
    apply(5'd11, 32'h00000000, 32'h0, 16'hf00f, 5'd0);      // R5
    apply(5'd12, 32'hffffffff, 32'h0, 16'hffff, 5'd0);      // R5
    apply(5'd9, 32'h0f0f0000, 32'h000000ff, 16'h0, 5'd0);   // R6 nor
    apply(5'd13, 32'hffffffff, 32'h00000001, 16'h0, 5'd0);  // R7 signed less
    apply(5'd14, 32'hffffffff, 32'h00000001, 16'h0, 5'd0);  // R7 unsigned not less
    apply(5'd15, 32'hfffffffe, 32'h0, 16'hffff, 5'd0);      // R7 slti
    apply(5'd16, 32'h00000005, 32'h0, 16'hffff, 5'd0);      // R7 sltiu sign-extended imm
    apply(5'd19, 32'h0, 32'h80000000, 16'h0, 5'd31);        // R8 sign fill
    apply(5'd18, 32'h0, 32'h80000000, 16'h0, 5'd31);        // R8 zero fill
    apply(5'd17, 32'h0, 32'h00000003, 16'h0, 5'd31);        // R8
    apply(5'd22, 32'hffffffe4, 32'h80000000, 16'h0, 5'd0);  // R9 upper bits ignored
    apply(5'd20, 32'h00000120, 32'h00000001, 16'h0, 5'd7);  // R9 amount 0
    apply(5'd23, 32'hffffffff, 32'hffffffff, 16'habcd, 5'd3); // R10
    apply(5'd24, 32'h7fffffff, 32'h7fffffff, 16'hffff, 5'd1); // R1 unused code
    apply(5'd31, 32'h80000000, 32'h80000000, 16'hffff, 5'd1); // R1 unused code

    for (int op = 0; op < 32; op++) begin
      for (int n = 0; n < 300; n++) begin
        logic [31:0] ra, rb;
        ra = $urandom;
        rb = $urandom;
        if (n % 4 == 0) ra = {ra[31], {31{ra[30]}}};
        if (n % 5 == 0) rb = {ra[31], rb[30:0]};
        apply(5'(op), ra, rb, 16'($urandom), 5'($urandom));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule